// File: doc/BRIEF.md
# Banked GPIO Controller with Combined Interrupt

The block is a memory-mapped general-purpose I/O peripheral. It gives a host three banks of 32 pins through a plain 32-bit register bus with an address, a write strobe with write data, and a read strobe with read data. For each pin the host sets the direction, whether the input is inverted, and the output level. Output levels can be written whole or changed bit by bit through separate write-one-to-set and write-one-to-clear locations, so no read-modify-write is needed.

Pin inputs cross into the clock domain through a two-flop synchroniser. After an optional inversion, each pin has four separate sense enables: rising edge, falling edge, high level and low level. Any enabled condition that holds marks the pin pending. The host clears pending bits by writing ones. One interrupt line serves all banks and stays high while any pending bit is set. A read-only register holds the direction of the last edge seen on each pin.

Registers are grouped by function. Each group takes 16 bytes and the banks sit inside a group at a 4-byte stride, so a register's byte address is the group base plus four times the bank number. Read data is registered and appears on the cycle after the read strobe.

Top module: `gpio_irq_banks`

## Requirements
- R1: After synchronous reset every register is zero, `pin_oe`, `pin_out` and `irq` are low, and every readable register returns zero.
- R2: A register's byte address is group base + 4 × bank, with banks 0..2 and the group bases: direction 0x00, invert 0x10, output 0x20, set 0x30, clear 0x40, rise enable 0x50, fall enable 0x60, high enable 0x70, low enable 0x80, pending 0x90, last edge 0xA0. An access to one bank leaves the other banks unchanged.
- R3: A direction bit of 1 drives the matching `pin_oe` bit high (output) and 0 leaves it low (input). `pin_out` always shows the output register.
- R4: A write to the output group loads the output register. In the set group each 1 sets an output bit, in the clear group each 1 clears one, and 0 bits leave the bits unchanged. The set and clear groups read as zero.
- R5: A read of the output group returns the output register bit for output pins and the synchronised pin level for input pins.
- R6: A pin change that meets an enabled edge condition sets its pending bit and `irq` on the third rising clock edge after the change, and not before.
- R7: With the rise enable set, a 0-to-1 change of the (inverted) level sets the pending bit. With the fall enable set, a 1-to-0 change sets it. A change in a direction whose enable is clear sets nothing.
- R8: With the high or low enable set, the pending bit is set again on every clock while the level condition holds, so clearing it takes effect only after the condition ends.
- R9: Writing 1 to a pending bit clears it and writing 0 leaves it. When a clear and a new event fall on the same clock, the event wins.
- R10: A pin whose four enables are all clear never becomes pending, whatever its input does.
- R11: An invert bit of 1 inverts that pin's synchronised input before edge and level detection.
- R12: The last-edge register holds 1 after the most recent edge was rising and 0 after a falling one. It records edges whatever the enables are, and bus writes to it are ignored.
- R13: `irq` is high exactly when at least one pending bit in any bank is set, and it changes on the same clock as the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe; data is valid on the next cycle |
| bus_rdata | output | DATA_W | Registered read data |
| pin_in | input | NUM_BANKS×DATA_W | Asynchronous pin inputs, bank 0 in the low bits |
| pin_out | output | NUM_BANKS×DATA_W | Output register levels |
| pin_oe | output | NUM_BANKS×DATA_W | Output enables from the direction registers |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the default build: three banks of 32 bits, an 8-bit address and a two-stage synchroniser. This reaches the whole address map, including the last bank at the top of each group and bit 31 of the set location, and lets the bench count the exact three-edge latency from a pin change to the interrupt. Events are placed in banks 0 and 2 together to show that the shared interrupt stays high until both are cleared. One pin combines inversion with low-level sensing to show that the polarity is applied before detection.

// File: rtl/gpiob_pkg.sv
package gpiob_pkg;

    // Register groups; the nibble value is the group base address >> 4.
    typedef enum logic [3:0] {
        RG_DIR   = 4'h0,
        RG_INV   = 4'h1,
        RG_OUT   = 4'h2,
        RG_OSET  = 4'h3,
        RG_OCLR  = 4'h4,
        RG_RISE  = 4'h5,
        RG_FALL  = 4'h6,
        RG_HIGH  = 4'h7,
        RG_LOW   = 4'h8,
        RG_PEND  = 4'h9,
        RG_LEDGE = 4'hA
    } reg_grp_e;

    localparam logic [3:0] RG_LAST = 4'hA;

    typedef struct packed {
        logic     hit;
        reg_grp_e grp;
        logic [1:0] bank;
    } reg_sel_t;

    // Byte address: [7:4] group, [3:2] bank, [1:0] ignored.
    function automatic reg_sel_t decode_addr(input logic [7:0] a, input int unsigned nbanks);
        reg_sel_t s;
        s.grp  = reg_grp_e'(a[7:4]);
        s.bank = a[3:2];
        s.hit  = (a[7:4] <= RG_LAST) && ({30'b0, a[3:2]} < nbanks);
        return s;
    endfunction

endpackage

// File: rtl/gpiob_sync.sv
module gpiob_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= '0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpiob_bank.sv
module gpiob_bank
    import gpiob_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  reg_grp_e     grp,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] rd_word,
    output logic [W-1:0] dir,
    output logic [W-1:0] dout,
    output logic [W-1:0] pend,
    output logic [W-1:0] pend_next
);
    typedef struct packed {
        logic [W-1:0] rise;
        logic [W-1:0] fall;
        logic [W-1:0] high;
        logic [W-1:0] low;
    } sense_en_t;

    logic [W-1:0] dir_q, inv_q, out_q, pend_q, ledge_q, prev_q;
    sense_en_t    en_q;

    logic [W-1:0] lvl, rise_det, fall_det, hit_set, clr_mask;

    always_comb begin
        lvl      = pin_sync ^ inv_q;
        rise_det = lvl & ~prev_q;
        fall_det = ~lvl & prev_q;
        hit_set  = (rise_det & en_q.rise) | (fall_det & en_q.fall)
                 | (lvl & en_q.high)      | (~lvl & en_q.low);
        clr_mask = (wr_en && grp == RG_PEND) ? wdata : '0;
        pend_next = (pend_q & ~clr_mask) | hit_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q   <= '0;
            inv_q   <= '0;
            out_q   <= '0;
            en_q    <= '0;
            pend_q  <= '0;
            ledge_q <= '0;
            prev_q  <= '0;
        end else begin
            prev_q  <= lvl;
            pend_q  <= pend_next;
            ledge_q <= (ledge_q | rise_det) & ~fall_det;
            if (wr_en) begin
                unique case (grp)
                    RG_DIR:  dir_q      <= wdata;
                    RG_INV:  inv_q      <= wdata;
                    RG_OUT:  out_q      <= wdata;
                    RG_OSET: out_q      <= out_q | wdata;
                    RG_OCLR: out_q      <= out_q & ~wdata;
                    RG_RISE: en_q.rise  <= wdata;
                    RG_FALL: en_q.fall  <= wdata;
                    RG_HIGH: en_q.high  <= wdata;
                    RG_LOW:  en_q.low   <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (grp)
            RG_DIR:   rd_word = dir_q;
            RG_INV:   rd_word = inv_q;
            RG_OUT:   rd_word = (out_q & dir_q) | (pin_sync & ~dir_q);
            RG_RISE:  rd_word = en_q.rise;
            RG_FALL:  rd_word = en_q.fall;
            RG_HIGH:  rd_word = en_q.high;
            RG_LOW:   rd_word = en_q.low;
            RG_PEND:  rd_word = pend_q;
            RG_LEDGE: rd_word = ledge_q;
            default:  rd_word = '0;
        endcase
    end

    assign dir  = dir_q;
    assign dout = out_q;
    assign pend = pend_q;
endmodule

// File: rtl/gpio_irq_banks.sv
module gpio_irq_banks
    import gpiob_pkg::*;
#(
    parameter int NUM_BANKS   = 3,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic                        bus_wr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic                        bus_rd,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*DATA_W-1:0] pin_in,
    output logic [NUM_BANKS*DATA_W-1:0] pin_out,
    output logic [NUM_BANKS*DATA_W-1:0] pin_oe,
    output logic                        irq
);
    localparam int PIN_W = NUM_BANKS * DATA_W;

    reg_sel_t          sel;
    logic              hit;
    logic [PIN_W-1:0]  pin_sync;
    logic [PIN_W-1:0]  pend_all;
    logic [PIN_W-1:0]  pend_nx;
    logic [DATA_W-1:0] bank_rd [NUM_BANKS];
    logic [DATA_W-1:0] rd_sel;

    always_comb begin
        sel = decode_addr(bus_addr[7:0], NUM_BANKS);
        hit = sel.hit && ((bus_addr >> 8) == '0);
    end

    gpiob_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            gpiob_bank #(.W(DATA_W)) u_bank (
                .clk       (clk),
                .rst       (rst),
                .wr_en     (bus_wr && hit && (sel.bank == 2'(b))),
                .grp       (sel.grp),
                .wdata     (bus_wdata),
                .pin_sync  (pin_sync[b*DATA_W +: DATA_W]),
                .rd_word   (bank_rd[b]),
                .dir       (pin_oe[b*DATA_W +: DATA_W]),
                .dout      (pin_out[b*DATA_W +: DATA_W]),
                .pend      (pend_all[b*DATA_W +: DATA_W]),
                .pend_next (pend_nx[b*DATA_W +: DATA_W])
            );
        end
    endgenerate

    always_comb begin
        rd_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (sel.bank == 2'(b)) rd_sel = bank_rd[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            irq       <= 1'b0;
        end else begin
            if (bus_rd) bus_rdata <= hit ? rd_sel : '0;
            irq <= |pend_nx;
        end
    end
endmodule

// File: rtl/gpio_irq_banks_chk.sv
module gpio_irq_banks_chk #(
    parameter int NUM_BANKS = 3,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_wr,
    input logic [DATA_W-1:0]           bus_wdata,
    input logic [NUM_BANKS*DATA_W-1:0] pin_out,
    input logic [NUM_BANKS*DATA_W-1:0] pin_oe,
    input logic [NUM_BANKS*DATA_W-1:0] pend_all,
    input logic                        irq
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0 && !irq));

    p_oe_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> $stable(pin_oe));

    p_oset_bank0_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'('h30)) |=>
            ((pin_out[DATA_W-1:0] & $past(bus_wdata)) == $past(bus_wdata)));

    p_oclr_bank0_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'('h40)) |=>
            ((pin_out[DATA_W-1:0] & $past(bus_wdata)) == '0));

    p_pend_no_drop_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> (($past(pend_all) & ~pend_all) == '0));

    p_irq_pend_r13: assert property (@(posedge clk) disable iff (rst)
        irq == (pend_all != '0));
endmodule

bind gpio_irq_banks gpio_irq_banks_chk #(
    .NUM_BANKS (NUM_BANKS),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pend_all  (pend_all),
    .irq       (irq)
);

// File: tb/gpio_irq_banks_tb.sv
module gpio_irq_banks_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 3;
    localparam int DW  = 32;
    localparam int AW  = 8;
    localparam int PW  = NB * DW;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] bus_rdata;
    logic [PW-1:0] pin_in = '0;
    logic [PW-1:0] pin_out;
    logic [PW-1:0] pin_oe;
    logic          irq;

    int total = 0;
    int bad   = 0;

    logic [DW-1:0] exp_q [$];
    string         tag_q [$];
    logic          rd_seen = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_banks #(.NUM_BANKS(NB), .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // Monitor: a read issued at a posedge is compared on the following negedge.
    always @(posedge clk) rd_seen <= bus_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard: read data %h with no expected entry", bus_rdata);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    bad++;
                    $display("FAIL %s: read actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        chk("R1 irq", PW'(irq), '0);
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 pin_out", pin_out, '0);
        rd(8'h08, 32'h0, "R1 dir bank2");
        rd(8'h90, 32'h0, "R1 pend bank0");

        pin_in[63:32] = 32'hAAAA0000;

        // R3, R2: direction of bank 1 only
        wr(8'h04, 32'h0000FFFF);
        chk("R3 R2 pin_oe", pin_oe, {32'h0, 32'h0000FFFF, 32'h0});

        // R4: output load, set, clear
        wr(8'h24, 32'h12345678);
        chk("R4 load", pin_out, {32'h0, 32'h12345678, 32'h0});
        wr(8'h34, 32'h80000001);
        chk("R4 set", pin_out, {32'h0, 32'h92345679, 32'h0});
        wr(8'h44, 32'h00000078);
        chk("R4 clear", pin_out, {32'h0, 32'h92345601, 32'h0});
        rd(8'h34, 32'h0, "R4 set reads zero");

        // R5: mixed output/input read; R2 other bank unaffected
        rd(8'h24, 32'hAAAA5601, "R5 data bank1");
        rd(8'h20, 32'h0, "R2 data bank0");

        // R6, R7: rising edge on bank2 bit0
        wr(8'h58, 32'h1);
        pin_in[64] = 1'b1;
        idle(2);
        chk("R6 irq before third edge", PW'(irq), '0);
        idle(1);
        chk("R6 irq at third edge", PW'(irq), PW'(1));
        rd(8'h98, 32'h1, "R7 rise pend bank2");
        rd(8'hA8, 32'h1, "R12 last edge rising");

        // R9: write-zero keeps, write-one clears
        wr(8'h98, 32'h0);
        rd(8'h98, 32'h1, "R9 zero write");
        wr(8'h98, 32'h1);
        chk("R9 R13 irq after clear", PW'(irq), '0);

        // R7 negative, R12 falling and write ignored
        pin_in[64] = 1'b0;
        idle(4);
        rd(8'h98, 32'h0, "R7 fall not enabled");
        rd(8'hA8, 32'h0, "R12 last edge falling");
        wr(8'hA8, 32'hFFFFFFFF);
        rd(8'hA8, 32'h0, "R12 write ignored");

        // R7: falling enable bank0 bit5
        wr(8'h60, 32'h20);
        pin_in[5] = 1'b1;
        idle(4);
        rd(8'h90, 32'h0, "R7 rise with fall enable");
        pin_in[5] = 1'b0;
        idle(4);
        rd(8'h90, 32'h20, "R7 fall pend");
        chk("R13 irq fall", PW'(irq), PW'(1));
        wr(8'h90, 32'h20);
        rd(8'h90, 32'h0, "R9 fall cleared");

        // R8: high level bank0 bit7
        wr(8'h70, 32'h80);
        pin_in[7] = 1'b1;
        idle(4);
        rd(8'h90, 32'h80, "R8 high pend");
        wr(8'h90, 32'h80);
        rd(8'h90, 32'h80, "R8 re-set while held");
        pin_in[7] = 1'b0;
        idle(4);
        wr(8'h90, 32'h80);
        rd(8'h90, 32'h0, "R8 cleared after release");
        chk("R8 irq", PW'(irq), '0);

        // R11: inverted low-level on bank1 bit3 (pin 35 low)
        wr(8'h14, 32'h8);
        wr(8'h84, 32'h8);
        idle(4);
        rd(8'h94, 32'h0, "R11 inverted low pin is high");
        pin_in[35] = 1'b1;
        idle(4);
        rd(8'h94, 32'h8, "R11 inverted high pin is low");
        rd(8'h14, 32'h8, "R11 invert readback");

        // R10: all enables clear
        wr(8'h84, 32'h0);
        wr(8'h94, 32'h8);
        rd(8'h94, 32'h0, "R10 masked pin");
        chk("R10 irq", PW'(irq), '0);
        pin_in[9] = 1'b1;
        idle(4);
        pin_in[9] = 1'b0;
        idle(4);
        rd(8'h90, 32'h0, "R10 toggle unmasked none");

        // R13: events in two banks share irq
        wr(8'h50, 32'h1);
        pin_in[0]  = 1'b1;
        pin_in[64] = 1'b1;
        idle(4);
        chk("R13 irq two banks", PW'(irq), PW'(1));
        wr(8'h90, 32'h1);
        chk("R13 irq one bank left", PW'(irq), PW'(1));
        wr(8'h98, 32'h1);
        chk("R13 irq all clear", PW'(irq), '0);

        idle(3);
        if (exp_q.size() != 0) begin
            bad++;
            total++;
            $display("FAIL scoreboard: actual=%0d pending reads expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule